// File: doc/BRIEF.md
# Eight-Digit Shared-Segment Display Scanner

This block drives eight seven-segment digits that all hang on one common bus of eight segment lines. Each digit has its own select line. The block lights the digits one at a time, in a fixed round-robin order, and it does so fast enough that all eight look steadily lit. The digits form four two-digit decimal fields: player one score, player two score, time left, and the current prize value. The first three fields sit on small digits. The prize sits on two large digits.

The block takes a binary value for each field and shows it in decimal, tens digit then ones digit. Values above 99 are shown as 99. All four values are sampled together at the boundary between full scans, so a single scan never mixes old and new readings. Each digit slot begins with a short dark gap in which no select is active. This stops the pattern of one digit from bleeding into the next.

The small digits take an active-high select and active-high segments. The large digits are switched through an inverting transistor stage, so both their select and their segments are active-low. The block applies the correct polarity for each slot.

Top module: `seg_scan_mux`

## Requirements
- R1: Outside the dark gap, exactly one digit is enabled. Enablement is read through each digit's own polarity.
- R2: After reset, slot 0 is the active slot. The slot index then advances by one every SLOT_CYC clocks in the order 0,1,...,7 and wraps from 7 to 0. Select bit i belongs to slot i.
- R3: For the first BLANK_CYC clocks of every slot, no digit is enabled: small selects are 0 and large selects are 1.
- R4: On the small digits (slots 0–5), a select of 1 enables the digit and a segment bit of 1 lights that segment.
- R5: On the large digits (slots 6 and 7), a select of 0 enables the digit and a segment bit of 0 lights that segment. During these slots the segment bus carries the bitwise inverse of the small-digit pattern.
- R6: The slot-to-field mapping is as follows. Slots 0/1 show player one, slots 2/3 show player two, slots 4/5 show time left, and slots 6/7 show the prize. The even slot shows the tens digit and the odd slot shows the ones digit. A leading zero is shown.
- R7: Each field value from 0 to 99 is shown as its two decimal digits. In the active-high segment pattern, bit 0 is segment a through bit 6 segment g. The digit codes are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F and 9=6F (hex).
- R8: A field value above 99 is shown as 99.
- R9: Field values are captured on the clock edge that enters slot 0 from slot 7. A change on a field input is not shown until the next scan starts.
- R10: The decimal-point segment, bit 7, is dark on every digit.
- R11: While reset is asserted, and for the whole first scan after it, every field shows 0. In reset the block sits in the dark gap of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p1_score_i | input | VAL_W | Player one score, binary |
| p2_score_i | input | VAL_W | Player two score, binary |
| time_left_i | input | VAL_W | Time left, binary |
| prize_i | input | VAL_W | Collectible prize value, binary |
| dig_sel_o | output | 8 | Digit selects; bit i drives slot i, polarity per R4/R5 |
| seg_o | output | 8 | Shared segment bus; bit 0 = a … bit 6 = g, bit 7 = decimal point |

## Verification
The bench builds the block with SLOT_CYC=16, BLANK_CYC=3 and VAL_W=7. With these settings a full scan lasts 128 clocks, and every input code from 0 to 127 is reachable, including the clamp region above 99. Each field is swept through all 128 codes, with a distinct offset or scramble per field. The input changes are deliberately out of phase with the scan boundary, so many of them land in the middle of a scan and test the capture rule. Every clock of every slot is compared against an arithmetic model. This covers the dark gap, the large-digit inversion and the wrap from slot 7 back to slot 0.

// File: rtl/seg_mux_pkg.sv
package seg_mux_pkg;

   localparam int NUM_FIELDS = 4;
   localparam int NUM_DIG    = 2 * NUM_FIELDS;
   localparam int SEG_W      = 8;
   localparam int MAX_SHOWN  = 99;

   typedef logic [3:0] bcd_t;

   typedef struct packed {
      bcd_t tens;
      bcd_t ones;
   } dec_pair_t;

   // active-high pattern, bit0 = a ... bit6 = g
   function automatic logic [6:0] glyph7(input bcd_t d);
      logic [6:0] g;
      case (d)
         4'd0:    g = 7'h3F;
         4'd1:    g = 7'h06;
         4'd2:    g = 7'h5B;
         4'd3:    g = 7'h4F;
         4'd4:    g = 7'h66;
         4'd5:    g = 7'h6D;
         4'd6:    g = 7'h7D;
         4'd7:    g = 7'h07;
         4'd8:    g = 7'h7F;
         4'd9:    g = 7'h6F;
         default: g = 7'h00;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/seg_scan_timer.sv
module seg_scan_timer #(
   parameter int SLOT_CYC  = 100000,
   parameter int BLANK_CYC = 4,
   parameter int NUM_SLOTS = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   output logic [$clog2(NUM_SLOTS)-1:0] slot_o,
   output logic                         blank_o,
   output logic                         scan_load_o
);
   localparam int CNT_W  = $clog2(SLOT_CYC + 1);
   localparam int SLOT_W = $clog2(NUM_SLOTS);
   localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(SLOT_CYC - 1);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

   initial begin
      assert (SLOT_CYC > BLANK_CYC + 1)
         else $fatal(1, "slot must outlast its dark gap");
      assert (BLANK_CYC >= 0)
         else $fatal(1, "dark gap cannot be negative");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [SLOT_W-1:0] slot_q;
   logic              slot_end;

   assign slot_end = (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         slot_q <= '0;
      end else if (slot_end) begin
         cnt_q  <= '0;
         slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   generate
      if (BLANK_CYC == 0) begin : g_no_gap
         assign blank_o = 1'b0;
      end else begin : g_gap
         assign blank_o = (cnt_q < CNT_W'(BLANK_CYC));

         AST_GAP_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
            slot_end |=> blank_o);                                    // R3
      end
   endgenerate

   assign slot_o      = slot_q;
   assign scan_load_o = slot_end && (slot_q == SLOT_LAST);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LAST);                                             // R2
   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && slot_q != SLOT_LAST) |=> slot_q == $past(slot_q) + 1'b1); // R2
   AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && slot_q == SLOT_LAST) |=> slot_q == '0);            // R2
   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_end |=> $stable(slot_q));                                 // R2

endmodule

// File: rtl/seg_bin2bcd.sv
module seg_bin2bcd
   import seg_mux_pkg::*;
#(
   parameter int VAL_W = 8
) (
   input  logic [VAL_W-1:0] bin_i,
   output dec_pair_t        dec_o
);
   localparam longint MAXV = (64'd1 << VAL_W) - 1;

   initial begin
      assert (VAL_W >= 1 && VAL_W <= 16)
         else $fatal(1, "field width out of supported range");
   end

   logic [6:0] lim;
   logic [6:0] rem;
   bcd_t       tens;

   generate
      if (MAXV > MAX_SHOWN) begin : g_clamp
         assign lim = (bin_i > VAL_W'(MAX_SHOWN)) ? 7'(MAX_SHOWN) : bin_i[6:0];
      end else begin : g_pass
         assign lim = 7'(bin_i);
      end
   endgenerate

   always_comb begin
      tens = '0;
      for (int k = 1; k <= 9; k++) begin
         if (lim >= 7'(10 * k)) tens = 4'(k);
      end
      rem = lim - (7'(tens) * 7'd10);
   end

   assign dec_o.tens = tens;
   assign dec_o.ones = rem[3:0];

endmodule

// File: rtl/seg_snapshot.sv
module seg_snapshot
   import seg_mux_pkg::*;
#(
   parameter int VAL_W = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              load_i,
   input  logic [NUM_FIELDS-1:0][VAL_W-1:0]  fields_i,
   output dec_pair_t [NUM_FIELDS-1:0]        snap_o
);
   dec_pair_t [NUM_FIELDS-1:0] conv;
   dec_pair_t [NUM_FIELDS-1:0] snap_q;

   generate
      for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
         seg_bin2bcd #(.VAL_W(VAL_W)) u_conv (
            .bin_i (fields_i[f]),
            .dec_o (conv[f])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      snap_q[f] <= '0;
            else if (load_i) snap_q[f] <= conv[f];
         end

         AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            snap_q[f].tens <= 4'd9 && snap_q[f].ones <= 4'd9);        // R7
         AST_CLAMP_99: assert property (@(posedge clk) disable iff (!rst_n)
            (load_i && 32'(fields_i[f]) > 32'(MAX_SHOWN))
            |=> snap_q[f] == {4'd9, 4'd9});                            // R8
      end
   endgenerate

   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(snap_q));                                   // R9

   assign snap_o = snap_q;

endmodule

// File: rtl/seg_scan_mux.sv
module seg_scan_mux
   import seg_mux_pkg::*;
#(
   parameter int              SLOT_CYC   = 100000,
   parameter int              BLANK_CYC  = 4,
   parameter int              VAL_W      = 8,
   parameter logic [NUM_DIG-1:0] LARGE_MASK = 8'hC0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VAL_W-1:0] p1_score_i,
   input  logic [VAL_W-1:0] p2_score_i,
   input  logic [VAL_W-1:0] time_left_i,
   input  logic [VAL_W-1:0] prize_i,
   output logic [7:0]       dig_sel_o,
   output logic [7:0]       seg_o
);
   localparam int SLOT_W = $clog2(NUM_DIG);

   initial begin
      assert (NUM_DIG == 8 && SEG_W == 8)
         else $fatal(1, "port widths assume eight digits and eight segments");
   end

   logic [SLOT_W-1:0]                slot;
   logic                             blank;
   logic                             scan_load;
   logic [NUM_FIELDS-1:0][VAL_W-1:0] fields;
   dec_pair_t [NUM_FIELDS-1:0]       snap;
   dec_pair_t                        cur_pair;
   bcd_t                             cur_dig;
   logic [SEG_W-1:0]                 lit_hi;
   logic [NUM_DIG-1:0]               on_vec;

   assign fields = {prize_i, time_left_i, p2_score_i, p1_score_i};

   seg_scan_timer #(
      .SLOT_CYC  (SLOT_CYC),
      .BLANK_CYC (BLANK_CYC),
      .NUM_SLOTS (NUM_DIG)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_o      (slot),
      .blank_o     (blank),
      .scan_load_o (scan_load)
   );

   seg_snapshot #(.VAL_W(VAL_W)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (scan_load),
      .fields_i (fields),
      .snap_o   (snap)
   );

   // slot pair (2k, 2k+1) belongs to field k; even slot = tens
   assign cur_pair = snap[slot[SLOT_W-1:1]];
   assign cur_dig  = slot[0] ? cur_pair.ones : cur_pair.tens;
   assign lit_hi   = {1'b0, glyph7(cur_dig)};

   generate
      for (genvar i = 0; i < NUM_DIG; i++) begin : g_dig
         assign on_vec[i] = !blank && (slot == SLOT_W'(i));
         if (LARGE_MASK[i]) begin : g_low
            assign dig_sel_o[i] = ~on_vec[i];
         end else begin : g_high
            assign dig_sel_o[i] = on_vec[i];
         end
      end
   endgenerate

   assign seg_o = LARGE_MASK[slot] ? ~lit_hi : lit_hi;

   AST_ONE_LIT: assert property (@(posedge clk) disable iff (!rst_n)
      !blank |-> $countones(dig_sel_o ^ LARGE_MASK) == 1);            // R1
   AST_SEL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !blank |-> (dig_sel_o ^ LARGE_MASK) == (8'b1 << slot));         // R2
   AST_DARK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> dig_sel_o == LARGE_MASK);                             // R3
   AST_DP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      seg_o[7] == LARGE_MASK[slot]);                                  // R10

endmodule

// File: tb/tb_seg_scan_mux.sv
module tb_seg_scan_mux;
   localparam int P = 16;
   localparam int B = 3;
   localparam int W = 7;
   localparam logic [7:0] M = 8'hC0;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] in_p1, in_p2, in_tm, in_pz;
   logic [7:0]   sel, seg;

   int  n_chk = 0;
   int  n_bad = 0;
   int  n_edge = 0;
   bit  run = 0;
   bit  done = 0;
   int  snap_v[4];

   always #4 clk = ~clk;

   seg_scan_mux #(.SLOT_CYC(P), .BLANK_CYC(B), .VAL_W(W), .LARGE_MASK(M)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .p1_score_i  (in_p1),
      .p2_score_i  (in_p2),
      .time_left_i (in_tm),
      .prize_i     (in_pz),
      .dig_sel_o   (sel),
      .seg_o       (seg)
   );

   function automatic logic [7:0] pat(input int d);
      case (d)
         0: return 8'h3F;  1: return 8'h06;  2: return 8'h5B;  3: return 8'h4F;
         4: return 8'h66;  5: return 8'h6D;  6: return 8'h7D;  7: return 8'h07;
         8: return 8'h7F;  9: return 8'h6F;
         default: return 8'h00;
      endcase
   endfunction

   function automatic int clampv(input int v);
      return (v > 99) ? 99 : v;
   endfunction

   function automatic int live(input int f);
      case (f)
         0: return int'(in_p1);
         1: return int'(in_p2);
         2: return int'(in_tm);
         default: return int'(in_pz);
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s at edge %0d: actual=%h expected=%h", tag, n_edge, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   // model: capture on the edge that enters slot 0 (R9), count edges after reset
   always @(posedge clk) begin
      if (rst_n) begin
         if (((n_edge + 1) % (8 * P)) == 0) begin
            for (int f = 0; f < 4; f++) snap_v[f] = clampv(live(f));
         end
         n_edge = n_edge + 1;
      end
   end

   always @(negedge clk) begin
      if (run) begin
         int cnt, slot, f, d, raw;
         logic [7:0] e_on, e_seg;
         string st, gt;
         cnt  = n_edge % P;
         slot = (n_edge / P) % 8;
         e_on = (cnt >= B) ? (8'b1 << slot) : 8'h00;
         if (cnt < B)            st = "R3";
         else if (cnt == B)      st = "R2";
         else if (slot >= 6)     st = "R5";
         else                    st = "R4";
         check(st, sel, e_on ^ M);
         check("R1", 8'($countones(sel ^ M)), (cnt >= B) ? 8'd1 : 8'd0);
         f     = slot / 2;
         d     = (slot % 2 == 0) ? snap_v[f] / 10 : snap_v[f] % 10;
         e_seg = pat(d);
         if (M[slot]) e_seg = ~e_seg;
         raw = live(f);
         if (clampv(raw) != snap_v[f]) gt = "R9";
         else if (raw > 99)            gt = "R8";
         else if (slot >= 6)           gt = "R5";
         else if (slot % 2 == 0)       gt = "R6";
         else                          gt = "R7";
         check(gt, seg, e_seg);
         check("R10", {7'd0, seg[7]}, {7'd0, M[slot]});
      end
   end

   initial begin
      for (int v = 0; v < 4; v++) snap_v[v] = 0;
      in_p1 = 7'd42; in_p2 = 7'd120; in_tm = 7'd7; in_pz = 7'd99;
      repeat (5) @(negedge clk);
      check("R11", sel, M);          // dark gap of slot 0 in reset
      check("R11", seg, 8'h3F);      // field shows 0 while reset held
      rst_n = 1'b1;
      run   = 1;
      for (int v = 0; v < 130; v++) begin
         @(negedge clk);
         in_p1 = W'(v % 128);
         in_p2 = W'(127 - (v % 128));
         in_tm = W'((v * 3) % 128);
         in_pz = W'((v + 50) % 128);
         repeat (8 * P + 5) @(negedge clk);
      end
      run = 0;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=expired expected=finished");
         finish_run();
      end
   end

endmodule